// File: doc/BRIEF.md
# Frame-Slotted Shared Bus Access Arbiter

This block lets one device win and hold a shared, open-drain control line against other devices on the same serial frame bus. Each frame carries one control octet. The block reads a bus-busy flag in that octet, and the flag reads 1 when the bus is free. If a local request is pending, the block may then contend. It contends by putting its 3-bit device address on the wired-AND line, most significant bit first, one bit per slot. On each slot it compares the bit it drove with the bit it reads back. Because 0 dominates the line, the lowest contending address survives.

The winner holds the bus from the next frame onwards. In every frame that follows it pulls the busy flag low and drives its address, and it keeps doing so until the request is withdrawn. After a win the block is demoted. It does not contend again until two consecutive frames have shown the bus free. When no device drives the line, the address field floats to all ones, so address 7 is the owner by default. A second control line carries a stop/go flag in the same bit position. The block turns it into a transmit enable for the local frame transmitter.

Top module: `fba_bus_arbiter`

## Requirements
- R1: After reset, `owned`, `grant`, `lost`, `ctl_drive_low` and `tx_enable` are all 0.
- R2: A strobe that comes with `frame_sync` is slot 0, and each later strobe is the next slot. The control octet starts at slot CTL_OFFSET (default 8) and its bit 7 is sent first. The busy flag is octet bit 5, at slot CTL_OFFSET+2. The address occupies octet bits 4..2, at slots CTL_OFFSET+3..+5, sent MSB first. Each state change takes effect on the clock edge where `bit_strobe` is high. A drive value applies for the whole of the slot that follows that edge.
- R3: With no request pending and the bus not owned, the block never asserts `ctl_drive_low`, so the address field reads 7 (all ones).
- R4: A request is pending, the block is not demoted, and the busy flag reads 1 at its slot. The block then contends in that frame: for every address bit that is 0 it asserts `ctl_drive_low` during that bit's slot.
- R5: A contender that drives a 1 but reads back 0 raises `lost` for exactly one cycle, in the cycle after that slot's strobe. It drives nothing for the rest of the frame.
- R6: A contender that completes all three address slots without a mismatch raises `grant` for one cycle and sets `owned`, both in the cycle after the last address strobe.
- R7: If the busy flag reads 0, the block does not contend in that frame, whatever the request.
- R8: In each frame whose request is still pending at slot CTL_OFFSET+1, the owner pulls the busy flag low and drives its own address. If the request is low at that slot, `owned` falls and nothing is driven in that frame.
- R9: A win demotes the block. It is promoted again only when the busy flag has read 1 in two consecutive frames, and it may contend from the frame after the second one. A frame that reads busy restarts the count.
- R10: `tx_enable` takes the inverse of `sg_rx` on the busy-slot strobe: 0 on the line means go, 1 means stop. It holds that value until the next busy slot.
- R11: A request is either `req_sw` or `req_tx`, and either one alone is enough to contend and to hold ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | Marks the strobe of slot 0 |
| bit_strobe | input | 1 | One-cycle strobe per bit slot |
| req_sw | input | 1 | Software-held access request |
| req_tx | input | 1 | Access request from the local frame transmitter |
| my_addr | input | 3 | Programmed device address |
| ctl_rx | input | 1 | Read-back of the wired-AND control line |
| sg_rx | input | 1 | Stop/go control line (1 = stop) |
| ctl_drive_low | output | 1 | Pull the control line low (open-drain enable) |
| owned | output | 1 | Level: the bus is held by this device |
| grant | output | 1 | One-cycle pulse on a won contention |
| lost | output | 1 | One-cycle pulse on an address mismatch |
| tx_enable | output | 1 | Transmit permitted (stop/go read as go) |

## Verification
The contention is tried with rival addresses chosen to part at each address bit. A rival that is higher at the MSB shows that this block wins. Rivals that are lower at the middle bit or at the LSB show that the lost pulse falls in the right slot and that the block stops driving after it. Directed frame sequences cover release, two-frame back-off and a busy frame in between, which tell a correct back-off counter apart from one that never restarts or that promotes too early. Random frames then mix requests from either source, a foreign owner, rivals, stop/go values and address changes. The whole driven slot pattern of each frame is compared, so a shifted slot or a stray drive also shows.

// File: rtl/fba_pkg.sv
// Shared definitions for the frame bus arbiter.
// Assumes an 8-bit control octet that is sent MSB first.
package fba_pkg;
    localparam int OCTET_BITS = 8;
    localparam int ADDR_W     = 3;
    localparam int BUSY_BIT   = 5;   // busy flag position within the octet
    localparam int ADDR_MSB   = 4;   // address occupies ADDR_MSB down to ADDR_MSB-ADDR_W+1

    // Role of the current slot within a frame
    typedef enum logic [2:0] {
        SLOT_OTHER,
        SLOT_PRE,
        SLOT_BUSY,
        SLOT_A2,
        SLOT_A1,
        SLOT_A0
    } slot_role_e;
endpackage

// File: rtl/fba_slot_timer.sv
// Slot position tracker. Counts bit strobes from frame_sync and names the
// role of the slot being strobed. Assumes frame_sync only arrives together
// with bit_strobe. The role is only meaningful while bit_strobe is high.
module fba_slot_timer
    import fba_pkg::*;
#(
    parameter int FRAME_SLOTS = 16,
    parameter int CTL_OFFSET  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_sync,
    input  logic       bit_strobe,
    output slot_role_e role
);
    localparam int CW        = $clog2(FRAME_SLOTS);
    localparam int BUSY_SLOT = CTL_OFFSET + (OCTET_BITS - 1 - BUSY_BIT);
    localparam int A2_SLOT   = CTL_OFFSET + (OCTET_BITS - 1 - ADDR_MSB);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] slot_now;

    assign slot_now = frame_sync ? '0 : cnt_q;

    // Advance the slot counter on every strobe, wrapping at the frame length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bit_strobe) begin
            cnt_q <= (slot_now == CW'(FRAME_SLOTS - 1)) ? '0 : slot_now + 1'b1;
        end
    end

    // Decode the role of the current slot
    always_comb begin
        role = SLOT_OTHER;
        if (slot_now == CW'(BUSY_SLOT - 1))    role = SLOT_PRE;
        else if (slot_now == CW'(BUSY_SLOT))   role = SLOT_BUSY;
        else if (slot_now == CW'(A2_SLOT))     role = SLOT_A2;
        else if (slot_now == CW'(A2_SLOT + 1)) role = SLOT_A1;
        else if (slot_now == CW'(A2_SLOT + 2)) role = SLOT_A0;
    end
endmodule

// File: rtl/fba_backoff.sv
// Back-off tracker. A win demotes the device. It is promoted again after
// FREE_FRAMES consecutive busy-slot samples that read free. A busy sample
// restarts the run. Assumes won and sample_en never coincide.
module fba_backoff #(
    parameter int FREE_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic bus_free,
    input  logic won,
    output logic demoted
);
    localparam int BW = $clog2(FREE_FRAMES + 1);

    logic [BW-1:0] run_q;

    // Count consecutive free frames and release the demotion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            demoted <= 1'b0;
        end else if (won) begin
            run_q   <= '0;
            demoted <= 1'b1;
        end else if (sample_en) begin
            if (bus_free) begin
                if (run_q != BW'(FREE_FRAMES)) run_q <= run_q + 1'b1;
                if (demoted && run_q == BW'(FREE_FRAMES - 1)) demoted <= 1'b0;
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/fba_stopgo.sv
// Stop/go capture. Samples the stop/go line at the busy slot and holds the
// transmit enable until the next frame. A line value of 1 means stop.
module fba_stopgo (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic sg_rx,
    output logic tx_enable
);
    // Latch the inverted stop flag once per frame
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_enable <= 1'b0;
        else if (sample_en) tx_enable <= !sg_rx;
    end
endmodule

// File: rtl/fba_bus_arbiter.sv
// Frame bus access arbiter, top level. Contends once per frame on a
// wired-AND address field, holds the bus by pulling the busy flag low, and
// backs off after a win. Assumes an open-drain line where 0 dominates.
// The drive value for a slot is set on the strobe of the slot before it.
module fba_bus_arbiter
    import fba_pkg::*;
#(
    parameter int FRAME_SLOTS = 16,
    parameter int CTL_OFFSET  = 8,
    parameter int FREE_FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              bit_strobe,
    input  logic              req_sw,
    input  logic              req_tx,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic              ctl_rx,
    input  logic              sg_rx,
    output logic              ctl_drive_low,
    output logic              owned,
    output logic              grant,
    output logic              lost,
    output logic              tx_enable
);
    slot_role_e slot_role;
    logic       demoted;
    logic       req;
    logic       contend_q;
    logic       cur_bit, nxt_bit, clash, keep, start;
    logic       busy_sample, win_now;

    fba_slot_timer #(
        .FRAME_SLOTS(FRAME_SLOTS),
        .CTL_OFFSET (CTL_OFFSET)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_sync(frame_sync),
        .bit_strobe(bit_strobe),
        .role      (slot_role)
    );

    assign req         = req_sw | req_tx;
    assign busy_sample = bit_strobe && (slot_role == SLOT_BUSY);

    // Select the address bit of this slot and of the next slot
    always_comb begin
        cur_bit = 1'b1;
        nxt_bit = 1'b1;
        case (slot_role)
            SLOT_BUSY: nxt_bit = my_addr[2];
            SLOT_A2: begin cur_bit = my_addr[2]; nxt_bit = my_addr[1]; end
            SLOT_A1: begin cur_bit = my_addr[1]; nxt_bit = my_addr[0]; end
            SLOT_A0: cur_bit = my_addr[0];
            default: ;
        endcase
        clash = contend_q && cur_bit && !ctl_rx;
        keep  = contend_q && !clash;
        start = !owned && req && !demoted && ctl_rx;
    end

    assign win_now = bit_strobe && (slot_role == SLOT_A0) && keep;

    fba_backoff #(
        .FREE_FRAMES(FREE_FRAMES)
    ) u_backoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(busy_sample),
        .bus_free (ctl_rx),
        .won      (win_now),
        .demoted  (demoted)
    );

    fba_stopgo u_stopgo (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(busy_sample),
        .sg_rx    (sg_rx),
        .tx_enable(tx_enable)
    );

    // Per-slot arbitration: release, contend, compare, and set the next drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owned         <= 1'b0;
            contend_q     <= 1'b0;
            ctl_drive_low <= 1'b0;
            grant         <= 1'b0;
            lost          <= 1'b0;
        end else begin
            grant <= 1'b0;
            lost  <= 1'b0;
            if (bit_strobe) begin
                case (slot_role)
                    SLOT_PRE: begin
                        if (owned && !req) owned <= 1'b0;
                        ctl_drive_low <= owned && req;
                    end
                    SLOT_BUSY: begin
                        contend_q     <= start;
                        ctl_drive_low <= (start || owned) && !nxt_bit;
                    end
                    SLOT_A2, SLOT_A1: begin
                        lost          <= clash;
                        contend_q     <= keep;
                        ctl_drive_low <= (keep || owned) && !nxt_bit;
                    end
                    SLOT_A0: begin
                        lost          <= clash;
                        contend_q     <= 1'b0;
                        ctl_drive_low <= 1'b0;
                        if (keep) begin
                            owned <= 1'b1;
                            grant <= 1'b1;
                        end
                    end
                    default: ctl_drive_low <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/fba_arbiter_chk.sv
// Property checker for the frame bus arbiter, attached by bind.
// Observes ports and the back-off state only.
module fba_arbiter_chk
    import fba_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input slot_role_e role,
    input logic       ctl_rx,
    input logic       ctl_drive_low,
    input logic       grant,
    input logic       lost,
    input logic       owned,
    input logic       demoted,
    input logic       tx_enable,
    input logic       sg_rx
);
    p_grant_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> owned);

    p_owned_rise_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owned) |-> grant);

    p_lost_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> $past(tick && !ctl_rx));

    p_lost_grant_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lost && grant));

    p_win_demotes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> demoted);

    p_owner_marks_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && role == SLOT_BUSY && owned) |-> ctl_drive_low);

    p_stopgo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && role == SLOT_BUSY) |=> $stable(tx_enable));

    p_stopgo_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && role == SLOT_BUSY) |=> (tx_enable == !$past(sg_rx)));
endmodule

bind fba_bus_arbiter fba_arbiter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (bit_strobe),
    .role         (slot_role),
    .ctl_rx       (ctl_rx),
    .ctl_drive_low(ctl_drive_low),
    .grant        (grant),
    .lost         (lost),
    .owned        (owned),
    .demoted      (demoted),
    .tx_enable    (tx_enable),
    .sg_rx        (sg_rx)
);

// File: tb/sim_fba_bus_arbiter.sv
// Bench for the frame bus arbiter: a frame-level reference model, a wired-AND
// line with a rival contender and a foreign owner, directed and random frames.
module sim_fba_bus_arbiter;
    localparam int FS        = 16;
    localparam int CO        = 8;
    localparam int BUSY_SLOT = CO + 2;
    localparam int A_BASE    = CO + 3;

    logic       clk = 1'b0, rst_n = 1'b0, frame_sync = 1'b0, bit_strobe = 1'b0;
    logic       req_sw = 1'b0, req_tx = 1'b0, sg_rx = 1'b1;
    logic [2:0] my_addr = 3'd3;
    logic       rival_low = 1'b0, other_low = 1'b0;
    logic       ctl_rx, ctl_drive_low, owned, grant, lost, tx_enable;

    int  n_chk = 0, n_bad = 0;
    bit  r_owned = 0, r_dem = 0;
    int  r_cnt = 0;

    always #2 clk = ~clk;

    assign ctl_rx = !(ctl_drive_low || rival_low || other_low);

    fba_bus_arbiter #(.FRAME_SLOTS(FS), .CTL_OFFSET(CO), .FREE_FRAMES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .bit_strobe(bit_strobe),
        .req_sw(req_sw), .req_tx(req_tx), .my_addr(my_addr), .ctl_rx(ctl_rx),
        .sg_rx(sg_rx), .ctl_drive_low(ctl_drive_low), .owned(owned), .grant(grant),
        .lost(lost), .tx_enable(tx_enable)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Requirement tag for the drive-pattern check of a frame
    function automatic string frame_tag(bit req, bit rt_only, bit own0, bit free, bit dem0);
        if (!req)     return "R3 idle";
        if (own0)     return "R8 owner";
        if (!free)    return "R7 busy";
        if (dem0)     return "R9 back-off";
        if (rt_only)  return "R11 tx request";
        return "R4 contend";
    endfunction

    // Slot index of address bit i (MSB first)
    function automatic int addr_slot(int i);
        return A_BASE + 2 - i;
    endfunction

    task automatic run_frame(input bit rs, input bit rt, input bit ob, input bit rv_on,
                             input logic [2:0] rv_addr, input bit sg);
        bit req, free, me_in, rv_in, me_low, rv_low, line, dem0, own0, win;
        logic [FS-1:0] exp_drv, obs_drv;
        int exp_lost, obs_lost, obs_grant, bi;
        string tag;
        req = rs | rt; own0 = r_owned; exp_drv = '0; obs_drv = '0;
        exp_lost = 0; obs_lost = 0; obs_grant = 0;
        // reference model of one frame
        if (r_owned && !req) r_owned = 0;
        exp_drv[BUSY_SLOT] = r_owned;
        free = !r_owned && !ob;
        dem0 = r_dem;
        if (free) begin
            if (r_cnt < 2) r_cnt++;
            if (r_dem && r_cnt == 2) r_dem = 0;
        end else r_cnt = 0;
        me_in = !r_owned && req && !dem0 && free;
        rv_in = rv_on && free;
        for (int i = 2; i >= 0; i--) begin
            me_low = (me_in || r_owned) && !my_addr[i];
            rv_low = rv_in && !rv_addr[i];
            line   = !(me_low || rv_low);
            exp_drv[addr_slot(i)] = me_low;
            if (me_in && my_addr[i] && !line) begin exp_lost++; me_in = 0; end
            if (rv_in && rv_addr[i] && !line) rv_in = 0;
        end
        win = me_in;
        if (win) begin r_owned = 1; r_dem = 1; r_cnt = 0; end
        tag = frame_tag(req, rt && !rs, own0, free, dem0);
        // drive the frame
        @(negedge clk);
        req_sw = rs; req_tx = rt; sg_rx = sg;
        rv_in = rv_on && free;
        for (int s = 0; s < FS; s++) begin
            @(negedge clk);
            bit_strobe = 1'b1;
            frame_sync = (s == 0);
            other_low  = ob && (s == BUSY_SLOT);
            bi = A_BASE + 2 - s;
            rival_low  = rv_in && (s >= A_BASE) && (s < A_BASE + 3) && !rv_addr[bi];
            #1;
            obs_drv[s] = ctl_drive_low;
            if (rv_in && (s >= A_BASE) && (s < A_BASE + 3) && rv_addr[bi] && !ctl_rx) rv_in = 0;
            @(negedge clk);
            bit_strobe = 1'b0; frame_sync = 1'b0; rival_low = 1'b0; other_low = 1'b0;
            if (lost)  obs_lost++;
            if (grant) obs_grant++;
        end
        chk({"R2 slot map, ", tag, " drive pattern"}, int'(obs_drv), int'(exp_drv));
        chk("R5 lost pulses", obs_lost, exp_lost);
        chk("R6 grant pulses", obs_grant, int'(win));
        chk("R8 ownership level", int'(owned), int'(r_owned));
        chk("R10 transmit enable", int'(tx_enable), int'(!sg));
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        bit rs, rt, ob, rv;
        logic [2:0] ra;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 owned after reset", int'(owned), 0);
        chk("R1 grant after reset", int'(grant), 0);
        chk("R1 lost after reset", int'(lost), 0);
        chk("R1 drive after reset", int'(ctl_drive_low), 0);
        chk("R1 tx_enable after reset", int'(tx_enable), 0);

        // R3 idle, R4/R6 win, R8 hold and release, R9 back-off with busy restart
        run_frame(0, 0, 0, 0, 3'd0, 1);
        run_frame(1, 0, 0, 0, 3'd0, 0);
        run_frame(1, 0, 0, 0, 3'd0, 1);
        run_frame(0, 0, 0, 0, 3'd0, 0);
        run_frame(1, 0, 1, 0, 3'd0, 0);
        run_frame(1, 0, 0, 0, 3'd0, 1);
        run_frame(1, 0, 0, 0, 3'd0, 0);
        run_frame(1, 0, 0, 0, 3'd0, 0);
        run_frame(1, 0, 0, 0, 3'd0, 1);
        run_frame(0, 0, 0, 0, 3'd0, 0);
        run_frame(0, 0, 0, 0, 3'd0, 0);
        run_frame(0, 0, 0, 0, 3'd0, 0);
        // R5 lose at middle bit, lose at LSB; R7 busy frame; R11 win by tx request
        run_frame(1, 0, 0, 1, 3'd1, 0);
        run_frame(1, 0, 0, 1, 3'd2, 1);
        run_frame(1, 0, 1, 0, 3'd0, 0);
        run_frame(0, 1, 0, 1, 3'd5, 0);
        run_frame(0, 1, 0, 0, 3'd0, 0);
        run_frame(0, 0, 0, 0, 3'd0, 1);

        // constrained random frames
        void'($urandom(32'h00c0ffee));
        for (int n = 0; n < 300; n++) begin
            if (($urandom % 8) == 0 && !r_owned) my_addr = 3'($urandom);
            rs = ($urandom % 3) != 0;
            rt = ($urandom % 4) == 0;
            ob = (($urandom % 5) == 0) && !r_owned;
            rv = ($urandom % 2) == 1;
            ra = my_addr ^ 3'(1 + ($urandom % 7));
            run_frame(rs, rt, ob, rv, ra, 1'($urandom));
        end
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end
endmodule